// File: doc/BRIEF.md
# Two-Button Speed Setting Controller

This block holds an unsigned speed setting that two push-button inputs step up and down. It is split into a small controller and a datapath. The controller is a four-state machine with the states init, idle, step-up and step-down. It drives three control lines into the datapath:

- a clear,
- a load enable,
- a direction select.

The datapath is a loadable speed register fed by an increment/decrement unit that stops at either end of the range.

The buttons are sampled on each rising clock edge. While exactly one button is held, the machine stays in the matching step state and loads one step per cycle. With neither button held, or both, it waits and the speed holds its value. Every change to the speed lands on the clock edge that leaves a state asserting load or clear, so the output trails the button by two edges. The buttons are assumed to be debounced already.

Top module: `speed_setter`

## Requirements
- R1: A clock edge with `rst` high sets `speed` to 0. The edge that follows, with `rst` low, leaves `speed` at 0 whatever the buttons are doing.
- R2: When `btn_up`=1 and `btn_dn`=0 are sampled at an edge, `speed` rises by exactly 1 at the next edge, provided it is below the maximum.
- R3: When `btn_up`=0 and `btn_dn`=1 are sampled at an edge, `speed` falls by exactly 1 at the next edge, provided it is above 0.
- R4: When both buttons are sampled high at an edge, `speed` is unchanged at the next edge.
- R5: When neither button is sampled high at an edge, `speed` is unchanged at the next edge.
- R6: While one button alone stays held, `speed` takes one step on every clock edge, with no idle cycles in between.
- R7: A step up from the maximum value (2^WIDTH-1, which is 15 at the default width) leaves `speed` at the maximum.
- R8: A step down from 0 leaves `speed` at 0.
- R9: `speed` changes only on the edge that follows a state asserting load or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_up | input | 1 | Increase button, active high |
| btn_dn | input | 1 | Decrease button, active high |
| speed | output | WIDTH | Registered speed setting |

## Verification
The bench builds the block with the default WIDTH of 4. With that width, sixteen held up-steps are enough to drive the speed into its top limit, and a long held down-run brings it back to the floor at 0. Button patterns cover single taps, long holds, both buttons at once, fast alternation, and a reset in the middle of a run. The two-edge latency from button to speed is checked against a behavioural model on every cycle.

// File: rtl/speed_setter.sv
module speed_setter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_up,
  input  logic             btn_dn,
  output logic [WIDTH-1:0] speed
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_INC, S_DEC} st_t;
  st_t st, st_nx;

  logic ld, dir, clr;
  logic [WIDTH-1:0] stepped;

  always_comb begin
    unique case ({btn_up, btn_dn})
      2'b10:   st_nx = S_INC;
      2'b01:   st_nx = S_DEC;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_INIT;
    else     st <= st_nx;
  end

  assign clr = (st == S_INIT);
  assign ld  = (st == S_INC) || (st == S_DEC);
  assign dir = (st == S_INC);

  assign stepped = dir ? ((speed == TOP) ? speed : speed + 1'b1)
                       : ((speed == '0)  ? speed : speed - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) speed <= '0;
    else if (ld)    speed <= stepped;
  end

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk)
    if (rst_seen) assert_reset_zero_R1: assert (speed == '0);

  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_INC && speed != TOP) |=> speed == $past(speed) + 1'b1);
  assert_step_dn_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && speed != '0) |=> speed == $past(speed) - 1'b1);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |=> $stable(speed));
  assert_run_stays_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_INC && btn_up && !btn_dn) |=> st == S_INC);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_INC && speed == TOP) |=> speed == TOP);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && speed == '0) |=> speed == '0);
  assert_change_only_after_load_R9: assert property (@(posedge clk) disable iff (rst)
    (!ld && !clr) |=> $stable(speed));
endmodule

// File: tb/test_speed_setter.sv
module test_speed_setter;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst = 1, btn_up = 0, btn_dn = 0;
  logic [W-1:0] speed;

  speed_setter #(.WIDTH(W)) i_speed_setter (
    .clk(clk), .rst(rst), .btn_up(btn_up), .btn_dn(btn_dn), .speed(speed));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int ref_spd = 0;
  int pend = 0;
  int last_act = 0;
  int run_len = 0;
  bit was_rst = 1;
  bit done = 0;

  always @(posedge clk) begin
    if (rst) begin
      ref_spd <= 0; pend <= 0; last_act <= 0; was_rst <= 1; run_len <= 0;
    end else begin
      was_rst <= 0;
      last_act <= pend;
      run_len <= (pend != 0 && pend == last_act) ? run_len + 1 : 0;
      if (pend > 0)      ref_spd <= (ref_spd == MAXV) ? MAXV : ref_spd + 1;
      else if (pend < 0) ref_spd <= (ref_spd == 0) ? 0 : ref_spd - 1;
      pend <= (btn_up && !btn_dn) ? 1 : (!btn_up && btn_dn) ? -1 : 0;
    end
  end

  function automatic string tag_now();
    if (was_rst) return "R1";
    if (last_act > 0 && run_len > 0) return (ref_spd == MAXV) ? "R7/R6" : "R6";
    if (last_act > 0) return (ref_spd == MAXV) ? "R7/R2" : "R2";
    if (last_act < 0 && run_len > 0) return (ref_spd == 0) ? "R8/R6" : "R6";
    if (last_act < 0) return (ref_spd == 0) ? "R8/R3" : "R3";
    return "R4/R5/R9";
  endfunction

  task automatic cyc(input bit u, input bit d);
    @(negedge clk);
    checks++;
    if (speed !== W'(ref_spd)) begin
      fails++;
      $display("FAIL %s: speed=%0d expected=%0d at %0t", tag_now(), speed, ref_spd, $time);
    end
    btn_up = u; btn_dn = d;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) cyc(0, 0);
    rst = 0;
    cyc(1, 0);                                // R1: buttons ignored right after reset
    repeat (3) cyc(0, 0);
    cyc(1, 0); repeat (3) cyc(0, 0);          // R2 single tap up
    cyc(1, 1); repeat (3) cyc(1, 1);          // R4 both held
    repeat (4) cyc(0, 0);                     // R5
    for (int k = 0; k < 20; k++) cyc(1, 0);   // R6 run, R7 saturate
    repeat (3) cyc(0, 0);
    cyc(0, 1); repeat (3) cyc(0, 0);          // R3 single tap down
    for (int k = 0; k < 20; k++) cyc(0, 1);   // R6 run, R8 saturate
    repeat (3) cyc(0, 0);
    for (int k = 0; k < 12; k++) cyc(k % 2 == 0, k % 2 == 1);
    for (int k = 0; k < 6; k++) cyc(1, 0);
    rst = 1; cyc(1, 0); cyc(1, 0);            // R1 reset mid-run
    rst = 0;
    for (int k = 0; k < 30; k++) cyc(k % 3 == 0, k % 5 == 0);
    repeat (4) cyc(0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule